// File: doc/BRIEF.md
# IDE PIO Strobe Timing Generator

This block produces the read and write strobes for PIO data-register accesses on one IDE channel that carries two drives. Each drive owns a 16-bit timing word in a small register file. The word sets how many clock units the strobe stays low (the active phase) and how many units it stays high before the next access may start (the recovery phase). It also has a flag that lets a slow device stretch the active phase by holding IORDY low. One clock period is one timing unit, nominally 30 ns.

A per-channel fast-mode bit chooses the timing source. When the bit is set, the selected drive's word is used. When it is clear, every access runs at a fixed slowest-mode timing and the per-drive words are ignored. A channel reset pulse clears the bit. Software computes the timing words; this block only counts them out. The timing word is captured when a request is accepted, so a word written while an access is running applies only to later accesses.

Requests use a valid/ready handshake. `req_ready` is high only while the block is idle. A request is accepted on a rising edge where both `req_valid` and `req_ready` are high. The requester must hold `req_valid`, `req_write` and `req_drive` stable until that edge. While an access is in flight, `req_ready` stays low and `req_valid` is ignored. `done` marks the last recovery cycle of the access, and `req_ready` rises in the cycle that follows.

Top module: `pio_strobe_gen`

## Requirements
- R1: After reset, `dior_n` and `diow_n` are high, `req_ready` is high, `done` and `err_o` are low, and the fast-mode bit is clear.
- R2: With fast mode set, a read drives only `dior_n` low and a write drives only `diow_n` low. The active phase lasts word[15:8]+1 cycles and the recovery phase lasts word[5:0]+1 cycles.
- R3: A zero active field and a zero recovery field each still give a one-cycle phase, so the word 0x0000 gives 1 active and 1 recovery cycle.
- R4: Word bit 6 (0x40) enables IORDY. When it is set, the active phase cannot end until the IORDY input, passed through two synchronizing flops, is seen high. The word 0x0240 with IORDY high gives 3 active and 1 recovery cycles. With bit 6 clear, IORDY has no effect.
- R5: If IORDY stays low with IORDY enabled, the active phase ends after word[15:8]+TMO_UNITS cycles (TMO_UNITS = 256 by default). `err_o` is then high in the cycle `done` is high, and only then.
- R6: With fast mode clear, every access uses 6 active and 14 recovery cycles, ignores IORDY, and ignores the drive's word.
- R7: A `chan_rst` pulse clears the fast-mode bit. It takes priority over a fast-mode write in the same cycle.
- R8: `req_ready` is high only when idle, and no strobe is low while idle. At most one strobe is low at a time. `done` lasts exactly one cycle, with both strobes high. Under a held `req_valid`, the next strobe falls two cycles after `done`.
- R9: A timing word written during an access, or on the edge that accepts the request, does not change that access. It applies from the next accepted access on.
- R10: `cfg_addr` values 0..NUM_DRIVES-1 select a drive's timing word, and `req_drive` selects the word used for an access. `cfg_addr` = NUM_DRIVES addresses the control register, whose bit 0 is the fast-mode bit. A write to one drive's word does not change another drive's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period is one timing unit |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_write | input | 1 | 1 = write access (diow_n), 0 = read access (dior_n) |
| req_drive | input | DRV_W | Drive index for the access |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | ADDR_W | 0..NUM_DRIVES-1 timing words, NUM_DRIVES control |
| cfg_wdata | input | 16 | Register write data |
| chan_rst | input | 1 | Channel reset pulse; clears fast mode |
| iordy | input | 1 | Asynchronous device ready line |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |
| done | output | 1 | One-cycle pulse in the last recovery cycle |
| err_o | output | 1 | IORDY timeout flag, valid with done |

## Verification
Two events can land on the same clock edge: a timing-word write and the acceptance of a request that reads that word. The bench raises `req_valid` and `cfg_we` in the same idle cycle. It expects the accepted access to use the old word and the following access to use the new one. The same approach covers a `chan_rst` pulse that coincides with a write setting the fast-mode bit, where the reset must win and mode-0 timing must follow. A scoreboard compares the strobe lengths it measures with the lengths it predicts.

// File: rtl/pio_strobe_pkg.sv
package pio_strobe_pkg;
  localparam int WORD_W   = 16;
  localparam int ACT_W    = 8;
  localparam int ACT_LSB  = 8;
  localparam int REC_W    = 6;
  localparam int RDY_BIT  = 6;

  typedef enum logic [1:0] {ST_IDLE, ST_ACT, ST_REC} pio_state_e;

  typedef struct packed {
    logic [ACT_W-1:0] act;
    logic [REC_W-1:0] rec;
    logic             rdy_en;
  } pio_timing_t;

  function automatic pio_timing_t unpack_word(input logic [WORD_W-1:0] w);
    pio_timing_t t;
    t.act    = w[ACT_LSB +: ACT_W];
    t.rec    = w[REC_W-1:0];
    t.rdy_en = w[RDY_BIT];
    return t;
  endfunction
endpackage

// File: rtl/pio_timing_regs.sv
module pio_timing_regs
  import pio_strobe_pkg::*;
#(
  parameter int NUM_DRIVES = 2,
  parameter int ADDR_W     = 2,
  parameter int DRV_W      = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              chan_rst,
  input  logic [DRV_W-1:0]  rd_drive,
  output logic [WORD_W-1:0] rd_word,
  output logic              fast_mode
);
  logic [WORD_W-1:0] words [NUM_DRIVES];

  for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        words[d] <= '0;
      else if (cfg_we && cfg_addr == ADDR_W'(d))
        words[d] <= cfg_wdata;
    end
  end

  // channel reset outranks a same-cycle control write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      fast_mode <= 1'b0;
    else if (chan_rst)
      fast_mode <= 1'b0;
    else if (cfg_we && cfg_addr == ADDR_W'(NUM_DRIVES))
      fast_mode <= cfg_wdata[0];
  end

  assign rd_word = words[rd_drive];
endmodule

// File: rtl/pio_sync2.sv
module pio_sync2 #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/pio_strobe_fsm.sv
module pio_strobe_fsm
  import pio_strobe_pkg::*;
#(
  parameter int TMO_UNITS = 256,
  localparam int TMO_W    = (TMO_UNITS > 2) ? $clog2(TMO_UNITS) : 1,
  localparam int CNT_W    = (ACT_W > REC_W) ? ACT_W : REC_W
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  output logic        req_ready,
  input  pio_timing_t tim_i,
  input  logic        rdy_s,
  output logic        dior_n,
  output logic        diow_n,
  output logic        done,
  output logic        err_o
);
  pio_state_e  state;
  pio_timing_t tim_q;
  logic [CNT_W-1:0] cnt;
  logic [TMO_W-1:0] wcnt;
  logic wr_q, err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      tim_q <= '0;
      cnt   <= '0;
      wcnt  <= '0;
      wr_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          state <= ST_ACT;
          tim_q <= tim_i;
          wr_q  <= req_write;
          cnt   <= CNT_W'(tim_i.act);
          wcnt  <= '0;
          err_q <= 1'b0;
        end
        ST_ACT: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (tim_q.rdy_en && !rdy_s) begin
            if (wcnt == TMO_W'(TMO_UNITS - 1)) begin
              err_q <= 1'b1;
              state <= ST_REC;
              cnt   <= CNT_W'(tim_q.rec);
            end else begin
              wcnt <= wcnt + 1'b1;
            end
          end else begin
            state <= ST_REC;
            cnt   <= CNT_W'(tim_q.rec);
          end
        end
        ST_REC: begin
          if (cnt == '0) state <= ST_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign dior_n    = !(state == ST_ACT && !wr_q);
  assign diow_n    = !(state == ST_ACT &&  wr_q);
  assign done      = (state == ST_REC) && (cnt == '0);
  assign err_o     = done && err_q;
endmodule

// File: rtl/pio_strobe_gen.sv
module pio_strobe_gen
  import pio_strobe_pkg::*;
#(
  parameter int NUM_DRIVES = 2,
  parameter int TMO_UNITS  = 256,
  parameter int MODE0_ACT  = 6,
  parameter int MODE0_REC  = 14,
  localparam int ADDR_W    = $clog2(NUM_DRIVES + 1),
  localparam int DRV_W     = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [DRV_W-1:0]  req_drive,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [15:0]       cfg_wdata,
  input  logic              chan_rst,
  input  logic              iordy,
  output logic              dior_n,
  output logic              diow_n,
  output logic              done,
  output logic              err_o
);
  logic [WORD_W-1:0] rd_word;
  logic              fast_mode;
  logic              rdy_s;
  pio_timing_t       sel_tim;
  logic              unused_spare;

  assign unused_spare = rd_word[7];

  pio_timing_regs #(
    .NUM_DRIVES(NUM_DRIVES), .ADDR_W(ADDR_W), .DRV_W(DRV_W)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .chan_rst(chan_rst), .rd_drive(req_drive),
    .rd_word(rd_word), .fast_mode(fast_mode)
  );

  pio_sync2 #(.RST_VAL(1'b1)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(iordy), .q(rdy_s)
  );

  always_comb begin
    if (fast_mode) begin
      sel_tim = unpack_word(rd_word);
    end else begin
      sel_tim.act    = ACT_W'(MODE0_ACT - 1);
      sel_tim.rec    = REC_W'(MODE0_REC - 1);
      sel_tim.rdy_en = 1'b0;
    end
  end

  pio_strobe_fsm #(.TMO_UNITS(TMO_UNITS)) fsm_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_ready(req_ready), .tim_i(sel_tim), .rdy_s(rdy_s),
    .dior_n(dior_n), .diow_n(diow_n), .done(done), .err_o(err_o)
  );
endmodule

// File: rtl/pio_strobe_chk.sv
module pio_strobe_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic dior_n,
  input logic diow_n,
  input logic done,
  input logic err_o
);
  // R8
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dior_n && !diow_n));
  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (dior_n && diow_n));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  done_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready);
  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (dior_n && diow_n));
  // R2
  strobe_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dior_n) || $fell(diow_n)) |-> $past(req_valid && req_ready));
  // R5
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> done);
endmodule

bind pio_strobe_gen pio_strobe_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .dior_n(dior_n), .diow_n(diow_n), .done(done), .err_o(err_o)
);

// File: tb/pio_strobe_gen_tb_top.sv
module pio_strobe_gen_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [0:0] req_drive = '0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic chan_rst = 1'b0, iordy = 1'b1;
  logic req_ready, dior_n, diow_n, done, err_o;

  pio_strobe_gen dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_drive(req_drive), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .chan_rst(chan_rst),
    .iordy(iordy), .dior_n(dior_n), .diow_n(diow_n), .done(done), .err_o(err_o)
  );

  typedef struct { string tag; int act; int rec; bit wr; bit err; } exp_t;
  exp_t expq[$];
  exp_t cur;
  int checks = 0, errors = 0;
  int act_n = 0, rec_n = 0;
  bit obs_wr = 1'b0;

  task automatic check(string tag, int got, int want);
    checks++;
    if (got != want) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, got, want);
    end
  endtask

  // monitor: measure each access and compare with the scoreboard queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (!dior_n || !diow_n) begin
        act_n++;
        obs_wr = !diow_n;
      end else if (act_n > 0) begin
        rec_n++;
      end
      if (done) begin
        if (expq.size() == 0) begin
          check("R8 done without pending access", 1, 0);
        end else begin
          cur = expq.pop_front();
          check({cur.tag, " active"}, act_n, cur.act);
          check({cur.tag, " recovery"}, rec_n, cur.rec);
          check({cur.tag, " direction"}, int'(obs_wr), int'(cur.wr));
          check({cur.tag, " error"}, int'(err_o), int'(cur.err));
        end
        act_n = 0;
        rec_n = 0;
      end
    end
  end

  task automatic cfg_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
  endtask

  task automatic push(string tag, int act, int rec, bit wr, bit err);
    exp_t e;
    e.tag = tag; e.act = act; e.rec = rec; e.wr = wr; e.err = err;
    expq.push_back(e);
  endtask

  // returns at the first negedge with the strobe low
  task automatic issue(input logic drv, input logic wr);
    wait_idle();
    req_drive = drv; req_write = wr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run(string tag, logic drv, logic wr, int act, int rec, bit err);
    push(tag, act, rec, wr, err);
    issue(drv, wr);
    wait_idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int gap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 dior_n", int'(dior_n), 1);
    check("R1 diow_n", int'(diow_n), 1);
    check("R1 req_ready", int'(req_ready), 1);
    check("R1 done", int'(done), 0);
    check("R1 err_o", int'(err_o), 0);
    // R1: fast mode clear after reset, so mode-0 timing
    cfg_write(2'd0, 16'h0240);
    run("R1 mode0 after reset", 1'b0, 1'b0, 6, 14, 1'b0);

    // R10: control register at address 2, bit 0 = fast mode
    cfg_write(2'd1, 16'h0305);
    cfg_write(2'd2, 16'h0001);
    run("R4 word 0x0240 read", 1'b0, 1'b0, 3, 1, 1'b0);
    run("R2 drive1 write", 1'b1, 1'b1, 4, 6, 1'b0);
    run("R2 drive1 read", 1'b1, 1'b0, 4, 6, 1'b0);

    // R3 zero fields
    cfg_write(2'd1, 16'h0000);
    run("R3 zero fields", 1'b1, 1'b1, 1, 1, 1'b0);
    run("R10 drive0 unchanged", 1'b0, 1'b0, 3, 1, 1'b0);

    // R4 IORDY extension: released 4 negedges after strobe falls
    cfg_write(2'd0, 16'h0040);
    iordy = 1'b0;
    push("R4 iordy stretch", 7, 1, 1'b0, 1'b0);
    issue(1'b0, 1'b0);
    repeat (4) @(negedge clk);
    iordy = 1'b1;
    wait_idle();

    // R4 iordy disabled: low IORDY has no effect
    cfg_write(2'd1, 16'h0200);
    iordy = 1'b0;
    run("R4 iordy disabled", 1'b1, 1'b0, 3, 1, 1'b0);

    // R5 timeout with IORDY stuck low
    cfg_write(2'd0, 16'h0240);
    run("R5 timeout", 1'b0, 1'b0, 2 + 256, 1, 1'b1);
    iordy = 1'b1;
    repeat (3) @(negedge clk);
    run("R5 error clears", 1'b0, 1'b0, 3, 1, 1'b0);

    // R6 fast mode clear: fixed timing, IORDY and words ignored
    cfg_write(2'd2, 16'h0000);
    iordy = 1'b0;
    run("R6 mode0 drive0", 1'b0, 1'b0, 6, 14, 1'b0);
    run("R6 mode0 drive1", 1'b1, 1'b1, 6, 14, 1'b0);
    iordy = 1'b1;

    // R7 channel reset clears fast mode
    cfg_write(2'd2, 16'h0001);
    run("R7 fast before reset", 1'b0, 1'b0, 3, 1, 1'b0);
    @(negedge clk); chan_rst = 1'b1;
    @(negedge clk); chan_rst = 1'b0;
    run("R7 after chan_rst", 1'b0, 1'b0, 6, 14, 1'b0);
    @(negedge clk);
    chan_rst = 1'b1; cfg_we = 1'b1; cfg_addr = 2'd2; cfg_wdata = 16'h0001;
    @(negedge clk);
    chan_rst = 1'b0; cfg_we = 1'b0;
    run("R7 reset beats write", 1'b0, 1'b0, 6, 14, 1'b0);

    // R9 word written during an access
    cfg_write(2'd2, 16'h0001);
    push("R9 old word mid-access", 3, 1, 1'b0, 1'b0);
    issue(1'b0, 1'b0);
    cfg_write(2'd0, 16'h0103);
    wait_idle();
    run("R9 new word next access", 1'b0, 1'b0, 2, 4, 1'b0);

    // R9 write on the acceptance edge
    wait_idle();
    push("R9 accept-edge old word", 2, 4, 1'b0, 1'b0);
    req_drive = 1'b0; req_write = 1'b0; req_valid = 1'b1;
    cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = 16'h0500;
    @(negedge clk);
    req_valid = 1'b0; cfg_we = 1'b0;
    wait_idle();
    run("R9 accept-edge new word", 1'b0, 1'b0, 6, 1, 1'b0);

    // R8 held valid: back-to-back accesses
    cfg_write(2'd0, 16'h0103);
    wait_idle();
    push("R8 back-to-back first", 2, 4, 1'b0, 1'b0);
    push("R8 back-to-back second", 2, 4, 1'b0, 1'b0);
    req_drive = 1'b0; req_write = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    check("R8 ready low while busy", int'(req_ready), 0);
    while (!done) @(negedge clk);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (dior_n && gap < 10);
    req_valid = 1'b0;
    check("R8 done to next strobe", gap, 2);
    wait_idle();
    check("R8 scoreboard drained", expq.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule